// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the horizontal and vertical timing of a raster display. Two free-running counters walk the pixel positions of a line and the lines of a frame. From them the block derives an active-video flag, a blanking signal, horizontal and vertical sync for a monitor, and a second, independently programmed pair of sync outputs for a flat panel.

Software sets the block up through a small 32-bit register bus. A key register guards the configuration. While the block is locked, writes to every other register are dropped. Writing the key opens the configuration and writing zero closes it again. Reads are never blocked.

Each timing register holds one window: a start value in its lower half and an end value in its upper half, both stored as the count minus one. Values written while the raster runs are held back until the next frame boundary, so a frame is never drawn with mixed timing.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset, every register reads 0 and the block is locked. Both counters are 0, blank_o is 1, and de_o and all four sync outputs are 0.
- R2: Register address 0 is the key register and reads 1 when unlocked, 0 when locked. Writing the key value 32'h5A3C9E17 there unlocks. Writing 0 locks. Any other value leaves the lock state unchanged. While locked, writes to every other address have no effect on the values read back. Reads are always served.
- R3: Addresses 2 to 9 are timing windows, in this order: horizontal total, horizontal blank, horizontal sync, panel horizontal sync, vertical total, vertical blank, vertical sync, panel vertical sync. Each holds start minus one in bits 15:0 and end minus one in bits 31:16. A window holding (s, e) covers counts c with s < c <= e. For the total registers, bits 15:0 hold the last active count and bits 31:16 the last count of the axis.
- R4: While running, h_count steps by one per clock from 0 up to the horizontal total field and then wraps to 0. v_count steps by one on each horizontal wrap and wraps to 0 after the vertical total field.
- R5: de_o is 1 only when the generator is enabled, h_count is at most the horizontal active field, and v_count is at most the vertical active field.
- R6: Address 1 is the control register: bit 0 enables the generator, bit 1 enables blanking, bit 2 horizontal sync, bit 3 vertical sync, bit 4 the panel syncs. blank_o is 1 whenever bit 0 is clear. When running, blank_o is 1 when bit 1 is set and either counter lies inside its blank window.
- R7: hsync_o and vsync_o are active high. Each is 1 when the generator runs, its enable bit is set, and its counter lies inside its sync window. Otherwise each is held at 0.
- R8: pnl_hsync_o and pnl_vsync_o follow their own windows at addresses 5 and 9 under control bit 4. Programming the panel vertical window one line lower than the monitor one makes the panel vertical sync lead by one line.
- R9: Timing writes made while the generator runs are read back at once. They change the raster only from the first frame that starts after the current frame ends.
- R10: While the generator enable is clear, both counters are held at 0 and newly written timing is used as soon as the generator starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| h_count | output | 16 | Pixel position within the line |
| v_count | output | 16 | Line position within the frame |
| de_o | output | 1 | Active video |
| blank_o | output | 1 | Blanking |
| hsync_o | output | 1 | Monitor horizontal sync |
| vsync_o | output | 1 | Monitor vertical sync |
| pnl_hsync_o | output | 1 | Panel horizontal sync |
| pnl_vsync_o | output | 1 | Panel vertical sync |

## Verification
The bench checks the exact first and last count of every window. A design that treated the stored start as inclusive, or the stored end as exclusive, would shift sync and blank by one pixel or line, and the output comparison catches that edge.

It rewrites the horizontal total partway through a running frame. A design without the frame-boundary hold would wrap the current line early. A design that loaded the new value one frame late would draw the next frame at the old width.

It tries timing and control writes with the key closed, after relocking, and with a value that is neither the key nor zero. A leaky lock shows up in read-back. A lock that any write toggles shows up in the key register.

It also clears single enable bits while running. A sync or blanking output not gated by its own enable would stay active.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter logic [31:0] UNLOCK_KEY = 32'h5A3C_9E17
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [15:0] h_count,
  output logic [15:0] v_count,
  output logic        de_o,
  output logic        blank_o,
  output logic        hsync_o,
  output logic        vsync_o,
  output logic        pnl_hsync_o,
  output logic        pnl_vsync_o
);
  localparam int NWIN = 8;
  localparam logic [3:0] A_KEY = 4'd0, A_CTRL = 4'd1, A_WIN0 = 4'd2;
  localparam int W_HTOT = 0, W_HBLK = 1, W_HSYN = 2, W_PNLH = 3;
  localparam int W_VTOT = 4, W_VBLK = 5, W_VSYN = 6, W_PNLV = 7;

  logic        open_q;
  logic [4:0]  ctrl_q;
  logic [31:0] win_q [NWIN];
  logic [31:0] win_s [NWIN];
  logic [15:0] hcnt, vcnt;

  wire run      = ctrl_q[0];
  wire blank_en = ctrl_q[1];
  wire hs_en    = ctrl_q[2];
  wire vs_en    = ctrl_q[3];
  wire pnl_en   = ctrl_q[4];

  wire win_hit  = bus_addr >= A_WIN0 && bus_addr < A_WIN0 + 4'(NWIN);
  wire [2:0] win_idx = 3'(bus_addr - A_WIN0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      ctrl_q <= '0;
      for (int i = 0; i < NWIN; i++) win_q[i] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_KEY) begin
        if (bus_wdata == UNLOCK_KEY) open_q <= 1'b1;
        else if (bus_wdata == '0)    open_q <= 1'b0;
      end else if (open_q) begin
        if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[4:0];
        else if (win_hit)       win_q[win_idx] <= bus_wdata;
      end
    end
  end

  wire line_end  = hcnt == win_s[W_HTOT][31:16];
  wire frame_end = line_end && vcnt == win_s[W_VTOT][31:16];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      for (int i = 0; i < NWIN; i++) win_s[i] <= '0;
    end else if (!run) begin
      hcnt <= '0;
      vcnt <= '0;
      for (int i = 0; i < NWIN; i++) win_s[i] <= win_q[i];
    end else if (line_end) begin
      hcnt <= '0;
      if (frame_end) begin
        vcnt <= '0;
        for (int i = 0; i < NWIN; i++) win_s[i] <= win_q[i];
      end else begin
        vcnt <= vcnt + 16'd1;
      end
    end else begin
      hcnt <= hcnt + 16'd1;
    end
  end

  function automatic logic inside_win(input logic [15:0] c, input logic [31:0] w);
    return (c > w[15:0]) && (c <= w[31:16]);
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_KEY)       bus_rdata = {31'd0, open_q};
    else if (bus_addr == A_CTRL) bus_rdata = {27'd0, ctrl_q};
    else if (win_hit)            bus_rdata = win_q[win_idx];
  end

  assign h_count     = hcnt;
  assign v_count     = vcnt;
  assign de_o        = run && hcnt <= win_s[W_HTOT][15:0] && vcnt <= win_s[W_VTOT][15:0];
  assign blank_o     = !run || (blank_en && (inside_win(hcnt, win_s[W_HBLK]) ||
                                             inside_win(vcnt, win_s[W_VBLK])));
  assign hsync_o     = run && hs_en  && inside_win(hcnt, win_s[W_HSYN]);
  assign vsync_o     = run && vs_en  && inside_win(vcnt, win_s[W_VSYN]);
  assign pnl_hsync_o = run && pnl_en && inside_win(hcnt, win_s[W_PNLH]);
  assign pnl_vsync_o = run && pnl_en && inside_win(vcnt, win_s[W_PNLV]);

  AST_LOCKED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !open_q && bus_addr == A_WIN0) |=> $stable(win_q[W_HTOT])); // R2
  AST_HCNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> hcnt <= win_s[W_HTOT][31:16]); // R4
  AST_VCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && line_end && !frame_end) |=> vcnt == $past(vcnt) + 16'd1); // R4
  AST_DE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    de_o |-> run); // R5
  AST_HSYNC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !hs_en |-> !hsync_o); // R7
  AST_PANEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pnl_en |-> !(pnl_hsync_o || pnl_vsync_o)); // R8
  AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !frame_end) |=> $stable(win_s[W_HTOT])); // R9
  AST_IDLE_COUNTERS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (hcnt == 16'd0 && vcnt == 16'd0)); // R10
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb_top;
  localparam logic [31:0] KEY = 32'h5A3C_9E17;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [15:0] h_count, v_count;
  logic de_o, blank_o, hsync_o, vsync_o, pnl_hsync_o, pnl_vsync_o;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  raster_timing_gen dut_i (.clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .h_count, .v_count, .de_o, .blank_o, .hsync_o, .vsync_o, .pnl_hsync_o, .pnl_vsync_o);

  logic [31:0] prog [8];
  logic [31:0] sh [8];
  logic [4:0]  m_ctrl;
  bit          m_open;
  int          mh, mv;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (h=%0d v=%0d)", tag, act, exp, mh, mv);
    end
  endtask

  function automatic bit inw(input int c, input logic [31:0] w);
    return c >= int'(w[15:0]) + 1 && c <= int'(w[31:16]);
  endfunction

  task automatic step();
    bit g;
    g = m_ctrl[0];
    chk("R4 R10 h_count", h_count, mh);
    chk("R4 R10 v_count", v_count, mv);
    chk("R5 de_o", de_o, g && mh <= int'(sh[0][15:0]) && mv <= int'(sh[4][15:0]));
    chk("R6 blank_o", blank_o, !g || (m_ctrl[1] && (inw(mh, sh[1]) || inw(mv, sh[5]))));
    chk("R3 R7 hsync_o", hsync_o, g && m_ctrl[2] && inw(mh, sh[2]));
    chk("R3 R7 vsync_o", vsync_o, g && m_ctrl[3] && inw(mv, sh[6]));
    chk("R8 pnl_hsync_o", pnl_hsync_o, g && m_ctrl[4] && inw(mh, sh[3]));
    chk("R8 pnl_vsync_o", pnl_vsync_o, g && m_ctrl[4] && inw(mv, sh[7]));
    if (!g) begin
      mh = 0; mv = 0; sh = prog;
    end else if (mh == int'(sh[0][31:16])) begin
      mh = 0;
      if (mv == int'(sh[4][31:16])) begin mv = 0; sh = prog; end
      else mv++;
    end else mh++;
    if (bus_wr) begin
      if (bus_addr == 0) begin
        if (bus_wdata == KEY) m_open = 1;
        else if (bus_wdata == 0) m_open = 0;
      end else if (m_open) begin
        if (bus_addr == 1) m_ctrl = bus_wdata[4:0];
        else if (bus_addr >= 2 && bus_addr <= 9) prog[bus_addr - 2] = bus_wdata;
      end
    end
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic t_reset();
    for (int a = 0; a < 10; a++) rd_chk("R1 reg after reset", 4'(a), 32'd0);
    chk("R1 blank_o", blank_o, 1);
    chk("R1 syncs", {de_o, hsync_o, vsync_o, pnl_hsync_o, pnl_vsync_o}, 0);
    run(3);
  endtask

  task automatic t_locked();
    wr(4'd2, 32'h0009_0005);
    wr(4'd1, 32'h1F);
    rd_chk("R2 locked window write", 4'd2, 32'd0);
    rd_chk("R2 locked ctrl write", 4'd1, 32'd0);
    wr(4'd0, 32'h1234_5678);
    rd_chk("R2 wrong key stays locked", 4'd0, 32'd0);
    run(4);
  endtask

  task automatic t_program();
    wr(4'd0, KEY);
    rd_chk("R2 key unlocks", 4'd0, 32'd1);
    wr(4'd0, 32'h0000_0001);
    rd_chk("R2 other value keeps open", 4'd0, 32'd1);
    wr(4'd2, {16'd9, 16'd5});
    wr(4'd3, {16'd9, 16'd5});
    wr(4'd4, {16'd8, 16'd6});
    wr(4'd5, {16'd8, 16'd6});
    wr(4'd6, {16'd5, 16'd3});
    wr(4'd7, {16'd5, 16'd3});
    wr(4'd8, {16'd4, 16'd3});
    wr(4'd9, {16'd3, 16'd2});
    rd_chk("R3 hsync window readback", 4'd4, {16'd8, 16'd6});
    rd_chk("R3 panel v window readback", 4'd9, {16'd3, 16'd2});
    run(3);
  endtask

  task automatic t_full_run();
    wr(4'd1, 32'h1F);
    rd_chk("R6 ctrl readback", 4'd1, 32'h1F);
    run(130);
  endtask

  task automatic t_gating();
    wr(4'd1, 32'h01);
    run(70);
    wr(4'd1, 32'h19);
    run(70);
    wr(4'd1, 32'h1F);
  endtask

  task automatic t_shadow();
    while (!(mh == 3 && mv == 2)) step();
    wr(4'd2, {16'd7, 16'd4});
    wr(4'd3, {16'd7, 16'd4});
    rd_chk("R9 readback immediate", 4'd2, {16'd7, 16'd4});
    while (!(mh == 9 && mv == 2)) step();
    chk("R9 old total still used", h_count, 9);
    run(70);
  endtask

  task automatic t_stop_relock();
    wr(4'd1, 32'h00);
    run(5);
    chk("R10 held at zero", {h_count, v_count}, 0);
    wr(4'd2, {16'd11, 16'd7});
    wr(4'd1, 32'h1F);
    run(80);
    wr(4'd0, 32'd0);
    rd_chk("R2 relocked", 4'd0, 32'd0);
    wr(4'd2, {16'd4, 16'd2});
    rd_chk("R2 relocked write dropped", 4'd2, {16'd11, 16'd7});
    run(20);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin prog[i] = '0; sh[i] = '0; end
    m_ctrl = '0; m_open = 0; mh = 0; mv = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_locked();
    t_program();
    t_full_run();
    t_gating();
    t_shadow();
    t_stop_relock();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule